// File: doc/BRIEF.md
# Dual-Channel Interval Timer with Shared Interrupt

This peripheral holds one or two identical interval counters behind a word-addressed 32-bit register bus. Each channel has a control word, a reload value and a live count. Software writes the reload value and then writes a control word with the run bit set. The channel copies the reload value into its count and steps by one on every clock, either downward toward zero or upward toward all ones.

When the count sits at its end value, the channel raises its pending flag on the next clock. It then either starts again from the reload value or stops. A single registered level interrupt is high while any channel has both its pending flag and its interrupt-enable bit set. Any write to a control word clears that channel's pending flag.

A build parameter selects how many channels exist. Addresses that decode to a channel which does not exist read as zero, and writes to them are dropped. Several control bits are kept for software but drive nothing: bit 0, bit 2, bit 3, bit 5, bit 9 and bit 10.

Top module: `twin_timer`

## Requirements
- R1: `addr` is a word address. Bits [1:0] pick the word inside a channel: 0 is control, 1 is reload, 2 is count and 3 is spare. The bits above them pick the channel. The spare word always reads zero, and writes to it are ignored.
- R2: A control write keeps only data bits [10:0]. Control reads return zero in bits [31:11].
- R3: After any control write, the pending flag (control bit 8) reads 0, even when the written data had bit 8 set.
- R4: A control write with the run bit (bit 7) set loads the count from the reload word at that clock edge, and counting starts on the following clock.
- R5: With the direction bit (bit 1) set, the count falls by one per clock. One clock after the count shows zero, the pending flag is set.
- R6: With bit 1 clear, the count rises by one per clock. One clock after the count shows 0xFFFFFFFF, the pending flag is set.
- R7: At expiry with the reload bit (bit 4) set, the count is reloaded from the reload word and counting continues. With bit 4 clear, the count stops and holds its end value.
- R8: `irq` is high when, one clock earlier, some channel had both its pending flag and its interrupt-enable bit (bit 6) set. Control bits 0, 2, 3, 5, 9 and 10 have no effect on counting or on `irq`.
- R9: When NUM_CH is 1, addresses whose channel field is nonzero read as zero, and writes to them are ignored.
- R10: Writes to the count word are ignored. A write to the reload word does not disturb a count that is already running.
- R11: A control write with bit 7 clear stops the channel, and the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word address: channel field above a 2-bit word field |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for `addr` |
| irq | output | 1 | Registered shared interrupt level |

## Verification
Properties are checked on every clock. They cover the flag clearing on a control write, the start from the reload word, the single step in each direction, the flag following expiry, the reload and the hold when stopped, the one-clock lag of the interrupt, and zero reads from the spare word and from absent channels. Only the bench scenarios show the cycle at which a complete count ends and how the two channels interact on the shared interrupt. The same applies to the masking of the upper control bits, the ignored stored bits, and the behaviour of a one-channel build.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CSR_W  = 11;
   localparam int B_DOWN = 1;
   localparam int B_AUTO = 4;
   localparam int B_IE   = 6;
   localparam int B_EN   = 7;
   localparam int B_FLAG = 8;

   typedef enum logic [1:0] {
      W_CTRL  = 2'd0,
      W_LOAD  = 2'd1,
      W_COUNT = 2'd2,
      W_SPARE = 2'd3
   } word_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 3,
   localparam int CH_W  = ADDR_W - 2
) (
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_CH-1:0]   ctrl_we,
   output logic [NUM_CH-1:0]   load_we,
   output logic [CH_W-1:0]     sel_ch,
   output word_e               sel_word,
   output logic                sel_hit
);
   assign sel_ch   = addr[ADDR_W-1:2];
   assign sel_word = word_e'(addr[1:0]);

   generate
      if (NUM_CH == (1 << CH_W)) begin : g_full
         assign sel_hit = 1'b1;
      end else begin : g_partial
         assign sel_hit = (32'(sel_ch) < NUM_CH);
      end
   endgenerate

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
         logic mine;
         assign mine       = wr_en && sel_hit && (sel_ch == CH_W'(c));
         assign ctrl_we[c] = mine && (sel_word == W_CTRL);
         assign load_we[c] = mine && (sel_word == W_LOAD);
      end
   endgenerate
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              load_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [CSR_W-1:0]  ctrl_q,
   output logic [DATA_W-1:0] load_q,
   output logic [DATA_W-1:0] count_q,
   output logic              irq_req
);
   logic running;
   logic at_end;
   logic expire;

   assign at_end  = ctrl_q[B_DOWN] ? (count_q == '0) : (count_q == '1);
   assign expire  = running && at_end;
   assign irq_req = ctrl_q[B_FLAG] && ctrl_q[B_IE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
      end else if (load_we) begin
         load_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         running <= 1'b0;
         count_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q         <= wdata[CSR_W-1:0];
         ctrl_q[B_FLAG] <= 1'b0;
         running        <= wdata[B_EN];
         if (wdata[B_EN]) begin
            count_q <= load_q;
         end
      end else if (expire) begin
         ctrl_q[B_FLAG] <= 1'b1;
         if (ctrl_q[B_AUTO]) begin
            count_q <= load_q;
         end else begin
            running <= 1'b0;
         end
      end else if (running) begin
         if (ctrl_q[B_DOWN]) begin
            count_q <= count_q - 1'b1;
         end else begin
            count_q <= count_q + 1'b1;
         end
      end
   end

   AST_CTRL_WR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> !ctrl_q[B_FLAG]); // R3
   AST_START_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && wdata[B_EN]) |=> (count_q == $past(load_q))); // R4
   AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (running && ctrl_q[B_DOWN] && (count_q != '0) && !ctrl_we)
      |=> (count_q == $past(count_q) - 1'b1)); // R5
   AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !ctrl_q[B_DOWN] && (count_q != '1) && !ctrl_we)
      |=> (count_q == $past(count_q) + 1'b1)); // R6
   AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctrl_we) |=> ctrl_q[B_FLAG]); // R5
   AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && ctrl_q[B_AUTO] && !ctrl_we) |=> (count_q == $past(load_q))); // R7
   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !ctrl_we) |=> $stable(count_q)); // R11
endmodule

// File: rtl/tmr_irq_merge.sv
module tmr_irq_merge #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   output logic              irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o <= 1'b0;
      end else begin
         irq_o <= |req;
      end
   end

   AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|req)); // R8
   AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> !$past(|req)); // R8
endmodule

// File: rtl/twin_timer.sv
module twin_timer
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   localparam int CH_W = ADDR_W - 2;

   initial begin
      assert (ADDR_W >= 3) else $error("ADDR_W must be at least 3");
      assert (NUM_CH >= 1) else $error("NUM_CH must be at least 1");
      assert (NUM_CH <= (1 << CH_W)) else $error("NUM_CH exceeds address field");
      assert (DATA_W >= CSR_W) else $error("DATA_W narrower than control word");
   end

   logic [NUM_CH-1:0]             ctrl_we;
   logic [NUM_CH-1:0]             load_we;
   logic [CH_W-1:0]               sel_ch;
   word_e                         sel_word;
   logic                          sel_hit;
   logic [NUM_CH-1:0][CSR_W-1:0]  ctrl_v;
   logic [NUM_CH-1:0][DATA_W-1:0] load_v;
   logic [NUM_CH-1:0][DATA_W-1:0] count_v;
   logic [NUM_CH-1:0]             req_v;

   tmr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
      .wr_en    (wr_en),
      .addr     (addr),
      .ctrl_we  (ctrl_we),
      .load_we  (load_we),
      .sel_ch   (sel_ch),
      .sel_word (sel_word),
      .sel_hit  (sel_hit)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         tmr_channel #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (ctrl_we[c]),
            .load_we (load_we[c]),
            .wdata   (wdata),
            .ctrl_q  (ctrl_v[c]),
            .load_q  (load_v[c]),
            .count_q (count_v[c]),
            .irq_req (req_v[c])
         );
      end
   endgenerate

   tmr_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_v),
      .irq_o (irq)
   );

   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (sel_hit && (sel_ch == CH_W'(c))) begin
            case (sel_word)
               W_CTRL:  rdata = {{(DATA_W-CSR_W){1'b0}}, ctrl_v[c]};
               W_LOAD:  rdata = load_v[c];
               W_COUNT: rdata = count_v[c];
               default: rdata = '0;
            endcase
         end
      end
   end

   AST_SPARE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_word == W_SPARE) |-> (rdata == '0)); // R1
   AST_ABSENT_CH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_hit |-> (rdata == '0)); // R9
   AST_ABSENT_CH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_hit |-> ((ctrl_we == '0) && (load_we == '0))); // R9
endmodule

// File: tb/twin_timer_test.sv
module twin_timer_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, wr_en1;
   logic [2:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata, rdata1;
   logic        irq, irq1;
   int          n_chk = 0;
   int          n_err = 0;

   always #10 clk = ~clk;

   twin_timer #(.NUM_CH(2)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq));

   twin_timer #(.NUM_CH(1)) uut_one (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en1), .addr(addr),
      .wdata(wdata), .rdata(rdata1), .irq(irq1));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, input bit one = 1'b0);
      addr  = a;
      wdata = d;
      if (one) wr_en1 = 1'b1; else wr_en = 1'b1;
      @(negedge clk);
      wr_en  = 1'b0;
      wr_en1 = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [31:0] d, input bit one = 1'b0);
      addr = a;
      #1;
      d = one ? rdata1 : rdata;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [32:0] predict(logic [31:0] ld, bit dn, bit ar, int n);
      logic [31:0] c = ld;
      bit run = 1'b1;
      bit fl = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (run) begin
            if (c == (dn ? 32'h0 : 32'hFFFF_FFFF)) begin
               fl = 1'b1;
               if (ar) c = ld; else run = 1'b0;
            end else begin
               c = dn ? c - 1 : c + 1;
            end
         end
      end
      return {fl, c};
   endfunction

   logic [31:0] v, ld, cw;
   logic [32:0] p, pm;
   bit          dn, ar, ie;
   int          k;
   logic [2:0]  base;

   initial begin
      #(20 * 200000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0; wr_en = 1'b0; wr_en1 = 1'b0; addr = '0; wdata = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // reset state
      bus_rd(3'd0, v); check("R2 reset ctrl", v, 32'h0);
      bus_rd(3'd2, v); check("R4 reset count", v, 32'h0);
      check("R8 reset irq", {31'b0, irq}, 32'h0);

      // R1 spare word
      bus_wr(3'd3, 32'hFFFF_FFFF);
      bus_rd(3'd3, v); check("R1 spare reads zero", v, 32'h0);
      bus_wr(3'd5, 32'h0000_0055);
      bus_rd(3'd1, v); check("R1 ch0 reload untouched by ch1", v, 32'h0);
      bus_rd(3'd5, v); check("R1 ch1 reload", v, 32'h55);
      bus_wr(3'd5, 32'h0);

      // R2 mask of control word
      bus_wr(3'd4, 32'hFFFF_FFFF);
      bus_rd(3'd4, v); check("R2 ctrl masked", v, 32'h0000_06FF);
      bus_wr(3'd4, 32'h0);
      tick(2);

      // R5 down count, one-shot
      bus_wr(3'd1, 32'd5);
      bus_wr(3'd0, 32'h0000_00C2);
      bus_rd(3'd2, v); check("R4 count starts at reload", v, 32'd5);
      tick(5);
      bus_rd(3'd2, v); check("R5 count reaches zero", v, 32'd0);
      bus_rd(3'd0, v); check("R5 flag not yet", {31'b0, v[8]}, 32'h0);
      tick(1);
      bus_rd(3'd0, v); check("R5 flag set after zero", {31'b0, v[8]}, 32'h1);
      check("R8 irq lags flag", {31'b0, irq}, 32'h0);
      tick(1);
      check("R8 irq rises", {31'b0, irq}, 32'h1);
      tick(3);
      bus_rd(3'd2, v); check("R7 one-shot holds zero", v, 32'd0);
      bus_wr(3'd0, 32'h0000_0140);
      bus_rd(3'd0, v); check("R3 ctrl write clears flag", {31'b0, v[8]}, 32'h0);
      tick(1);
      check("R8 irq falls", {31'b0, irq}, 32'h0);
      bus_wr(3'd0, 32'h0);

      // R6 and R7: up count with reload on channel 1
      bus_wr(3'd5, 32'hFFFF_FFFD);
      bus_wr(3'd4, 32'h0000_00D0);
      bus_rd(3'd6, v); check("R6 up start", v, 32'hFFFF_FFFD);
      tick(2);
      bus_rd(3'd6, v); check("R6 up reaches all ones", v, 32'hFFFF_FFFF);
      tick(1);
      bus_rd(3'd4, v); check("R6 flag after all ones", {31'b0, v[8]}, 32'h1);
      bus_rd(3'd6, v); check("R7 reload", v, 32'hFFFF_FFFD);
      tick(1);
      bus_rd(3'd6, v); check("R7 continues", v, 32'hFFFF_FFFE);
      check("R8 irq from ch1", {31'b0, irq}, 32'h1);
      bus_wr(3'd4, 32'h0);
      tick(1);

      // R10 and R11
      bus_wr(3'd1, 32'd100);
      bus_wr(3'd0, 32'h0000_0082);
      bus_wr(3'd1, 32'd7);
      bus_rd(3'd2, v); check("R10 reload write keeps count", v, 32'd99);
      bus_wr(3'd2, 32'h0000_1234);
      bus_rd(3'd2, v); check("R10 count write ignored", v, 32'd98);
      bus_rd(3'd1, v); check("R10 reload stored", v, 32'd7);
      bus_wr(3'd0, 32'h0000_0002);
      bus_rd(3'd2, v); check("R11 stop holds", v, 32'd98);
      tick(3);
      bus_rd(3'd2, v); check("R11 stays held", v, 32'd98);

      // R9 single-channel build
      bus_wr(3'd1, 32'h33, 1'b1);
      bus_wr(3'd5, 32'h77, 1'b1);
      bus_wr(3'd4, 32'h0000_00C2, 1'b1);
      bus_rd(3'd1, v, 1'b1); check("R9 ch0 present", v, 32'h33);
      bus_rd(3'd5, v, 1'b1); check("R9 absent reload zero", v, 32'h0);
      bus_rd(3'd4, v, 1'b1); check("R9 absent ctrl zero", v, 32'h0);
      tick(2);
      bus_rd(3'd2, v, 1'b1); check("R9 ch0 not started", v, 32'h0);

      // random runs, R8 stored bits without effect
      for (int it = 0; it < 30; it++) begin
         bus_wr(3'd0, 32'h0);
         bus_wr(3'd4, 32'h0);
         base = ($urandom_range(0, 1) == 1) ? 3'd4 : 3'd0;
         dn = $urandom_range(0, 1);
         ar = $urandom_range(0, 1);
         ie = $urandom_range(0, 1);
         ld = dn ? 32'($urandom_range(0, 15)) : 32'hFFFF_FFFF - 32'($urandom_range(0, 15));
         cw = 32'h80 | (dn ? 32'h2 : 32'h0) | (ar ? 32'h10 : 32'h0) | (ie ? 32'h40 : 32'h0)
              | ($urandom & 32'h0000_062D) | ($urandom & 32'h0000_0100) | ($urandom & 32'hFFFF_F800);
         k = $urandom_range(1, 40);
         bus_wr(base + 3'd1, ld);
         bus_wr(base, cw);
         tick(k);
         p  = predict(ld, dn, ar, k);
         pm = predict(ld, dn, ar, k - 1);
         bus_rd(base + 3'd2, v); check(dn ? "R5 random count" : "R6 random count", v, p[31:0]);
         bus_rd(base, v); check("R2 random ctrl", v, (cw & 32'h6FF) | {23'b0, p[32], 8'b0});
         check("R8 random irq", {31'b0, irq}, {31'b0, pm[32] & ie});
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule